// File: doc/BRIEF.md
# Table Lookup Linear Interpolator

This block applies an arbitrary smooth transfer function to a stream of signed 18-bit samples with 15 fractional bits. It does not evaluate a polynomial. It reads one entry of a coarse 1024-entry table for each sample and interpolates linearly between breakpoints.

Each table word holds two fields:
- the function value at a breakpoint;
- the signed first difference from that breakpoint to the next one.

The upper bits of the sample select the word. The lower bits scale the difference. Each output therefore costs one read, one multiply and one add.

A host loads the table through a write port. The write port supplies an address and both fields in the same cycle. The datapath is a three-stage pipeline, and each accepted sample yields exactly one result.

Top module: `interp_lut`

## Requirements
- R1: While rst_ni is low, and after its release until the first result, valid_o is 0 and data_o is 0.
- R2: A sample accepted with valid_i high at a rising edge produces valid_o high for exactly one cycle, three rising edges later (the edge of acceptance counts as the first). Samples on consecutive cycles give results on consecutive cycles, in the same order.
- R3: The table index is {~data_i[17], data_i[16:8]}. The most negative input (0x20000) selects index 0, zero selects index 512, and 0x1FFFF selects index 1023.
- R4: A write with wr_en_i high at a rising edge stores wr_value_i and wr_diff_i at wr_addr_i. Samples accepted at any later edge see the new word, and the new word replaces the old one completely.
- R5: When the fraction data_i[7:0] is 0, data_o equals the stored value exactly, whatever the difference field holds.
- R6: data_o = value + floor((diff * frac + 128) / 256), where frac = data_i[7:0] is unsigned (0..255). A fraction of exactly one half rounds upward.
- R7: A negative difference follows the same floor-based rounding. For example, diff = -3 with frac = 128 adds -1, and diff = -1 with frac = 128 adds 0.
- R8: A sum above 131071 gives data_o = 131071 (0x1FFFF).
- R9: A sum below -131072 gives data_o = -131072 (0x20000).
- R10: While valid_o is low, data_o holds the last result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Table write strobe |
| wr_addr_i | input | 10 | Table word index |
| wr_value_i | input | 18 | Breakpoint value to store |
| wr_diff_i | input | 18 | Signed difference to store |
| valid_i | input | 1 | Sample strobe |
| data_i | input | 18 | Signed input sample, Q2.15 |
| valid_o | output | 1 | Result strobe |
| data_o | output | 18 | Signed interpolated result, Q2.15 |

## Verification
The internal state is the table, the staged fraction and value, and the valid pipeline.
- A corrupted table word or a wrong index bit shows up three cycles after the first sample that touches that breakpoint. It appears as an offset that does not depend on the fraction.
- A fraction register out of step with its word shows up only for nonzero fractions. This is why results are compared at several fractions on the same entry.
- A broken valid stage shows at once as a missing, doubled or shifted strobe in a back-to-back burst.
- A wrong rounding or saturation bound shows only at the half-step and overflow corners, so entries are chosen to hit them directly.

// File: rtl/interp_pkg.sv
package interp_pkg;
  localparam int unsigned SAMPLE_W_DEF = 18;
  localparam int unsigned ADDR_W_DEF   = 10;
endpackage

// File: rtl/interp_table.sv
module interp_table #(
  parameter int unsigned SAMPLE_W = interp_pkg::SAMPLE_W_DEF,
  parameter int unsigned ADDR_W   = interp_pkg::ADDR_W_DEF
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       wr_en_i,
  input  logic [ADDR_W-1:0]          wr_addr_i,
  input  logic [SAMPLE_W-1:0]        wr_value_i,
  input  logic [SAMPLE_W-1:0]        wr_diff_i,
  input  logic                       valid_i,
  input  logic [SAMPLE_W-1:0]        sample_i,
  output logic                       valid_o,
  output logic [SAMPLE_W-1:0]        value_o,
  output logic [SAMPLE_W-1:0]        diff_o,
  output logic [SAMPLE_W-ADDR_W-1:0] frac_o
);
  localparam int unsigned FRAC_W = SAMPLE_W - ADDR_W;
  localparam int unsigned DEPTH  = 1 << ADDR_W;
  localparam int unsigned WORD_W = 2 * SAMPLE_W;

  logic [WORD_W-1:0] mem [DEPTH];
  logic [WORD_W-1:0] rd_q;
  logic [ADDR_W-1:0] rd_idx;

  // offset binary: invert sign so index 0 is most negative
  assign rd_idx = {~sample_i[SAMPLE_W-1], sample_i[SAMPLE_W-2:FRAC_W]};

  always_ff @(posedge clk_i) begin
    if (wr_en_i) mem[wr_addr_i] <= {wr_value_i, wr_diff_i};
  end

  // read-first: a same-edge write is seen by later samples only
  always_ff @(posedge clk_i) begin
    if (valid_i) rd_q <= mem[rd_idx];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      frac_o  <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) frac_o <= sample_i[FRAC_W-1:0];
    end
  end

  assign value_o = rd_q[WORD_W-1:SAMPLE_W];
  assign diff_o  = rd_q[SAMPLE_W-1:0];

  // R2
  stage1_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  // R2
  stage1_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);
endmodule

// File: rtl/interp_mul.sv
module interp_mul #(
  parameter int unsigned SAMPLE_W = interp_pkg::SAMPLE_W_DEF,
  parameter int unsigned FRAC_W   = 8
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  valid_i,
  input  logic [SAMPLE_W-1:0]   value_i,
  input  logic [SAMPLE_W-1:0]   diff_i,
  input  logic [FRAC_W-1:0]     frac_i,
  output logic                  valid_o,
  output logic [SAMPLE_W-1:0]   value_o,
  output logic [SAMPLE_W:0]     corr_o
);
  localparam int unsigned PROD_W = SAMPLE_W + FRAC_W + 1;
  localparam logic signed [PROD_W-1:0] HALF = PROD_W'(1) << (FRAC_W - 1);

  logic signed [PROD_W-1:0] prod_w;
  logic signed [PROD_W-1:0] rnd_w;

  assign prod_w = $signed(diff_i) * $signed({1'b0, frac_i});
  // round half up, then slice = arithmetic shift by FRAC_W
  assign rnd_w  = prod_w + HALF;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      value_o <= '0;
      corr_o  <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        value_o <= value_i;
        corr_o  <= rnd_w[PROD_W-1:FRAC_W];
      end
    end
  end

  // R5
  zero_frac_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && frac_i == '0) |=> corr_o == '0);
  // R6
  zero_diff_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && diff_i == '0) |=> corr_o == '0);
endmodule

// File: rtl/interp_sat_add.sv
module interp_sat_add #(
  parameter int unsigned SAMPLE_W = interp_pkg::SAMPLE_W_DEF
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                valid_i,
  input  logic [SAMPLE_W-1:0] value_i,
  input  logic [SAMPLE_W:0]   corr_i,
  output logic                valid_o,
  output logic [SAMPLE_W-1:0] data_o
);
  localparam int unsigned SUM_W = SAMPLE_W + 2;
  localparam logic signed [SUM_W-1:0] MAX_S = SUM_W'((1 << (SAMPLE_W - 1)) - 1);
  localparam logic signed [SUM_W-1:0] MIN_S = -MAX_S - SUM_W'(1);

  logic signed [SUM_W-1:0]    sum_w;
  logic        [SAMPLE_W-1:0] sat_w;

  assign sum_w = SUM_W'($signed(value_i)) + SUM_W'($signed(corr_i));

  always_comb begin
    if (sum_w > MAX_S)      sat_w = MAX_S[SAMPLE_W-1:0];
    else if (sum_w < MIN_S) sat_w = MIN_S[SAMPLE_W-1:0];
    else                    sat_w = sum_w[SAMPLE_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      data_o  <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) data_o <= sat_w;
    end
  end

  // R8
  no_wrap_pos_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !value_i[SAMPLE_W-1] && !corr_i[SAMPLE_W]) |=> !data_o[SAMPLE_W-1]);
  // R9
  no_wrap_neg_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && value_i[SAMPLE_W-1] && corr_i[SAMPLE_W]) |=> data_o[SAMPLE_W-1]);
  // R10
  hold_out_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(data_o));
  // R5
  pass_value_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && corr_i == '0) |=> data_o == $past(value_i));
endmodule

// File: rtl/interp_lut.sv
module interp_lut #(
  parameter int unsigned SAMPLE_W = interp_pkg::SAMPLE_W_DEF,
  parameter int unsigned ADDR_W   = interp_pkg::ADDR_W_DEF
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_en_i,
  input  logic [ADDR_W-1:0]   wr_addr_i,
  input  logic [SAMPLE_W-1:0] wr_value_i,
  input  logic [SAMPLE_W-1:0] wr_diff_i,
  input  logic                valid_i,
  input  logic [SAMPLE_W-1:0] data_i,
  output logic                valid_o,
  output logic [SAMPLE_W-1:0] data_o
);
  localparam int unsigned FRAC_W = SAMPLE_W - ADDR_W;

  logic                v1, v2;
  logic [SAMPLE_W-1:0] val1, dif1, val2;
  logic [FRAC_W-1:0]   frac1;
  logic [SAMPLE_W:0]   corr2;

  interp_table #(.SAMPLE_W(SAMPLE_W), .ADDR_W(ADDR_W)) u_table (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_value_i, .wr_diff_i,
    .valid_i, .sample_i(data_i),
    .valid_o(v1), .value_o(val1), .diff_o(dif1), .frac_o(frac1)
  );

  interp_mul #(.SAMPLE_W(SAMPLE_W), .FRAC_W(FRAC_W)) u_mul (
    .clk_i, .rst_ni, .valid_i(v1), .value_i(val1), .diff_i(dif1),
    .frac_i(frac1), .valid_o(v2), .value_o(val2), .corr_o(corr2)
  );

  interp_sat_add #(.SAMPLE_W(SAMPLE_W)) u_add (
    .clk_i, .rst_ni, .valid_i(v2), .value_i(val2), .corr_i(corr2),
    .valid_o, .data_o
  );

  // R2
  out_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    v2 |=> valid_o);
  // R1
  reset_out_chk: assert property (@(posedge clk_i)
    !rst_ni |-> (!valid_o && data_o == '0));
endmodule

// File: tb/sim_interp_lut.sv
module sim_interp_lut;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [9:0]  wr_addr_i = '0;
  logic [17:0] wr_value_i = '0, wr_diff_i = '0;
  logic        valid_i = 1'b0;
  logic [17:0] data_i = '0;
  logic        valid_o;
  logic [17:0] data_o;

  int n_chk = 0, n_fail = 0;
  int tv [1024];
  int td [1024];

  always #10 clk = ~clk;

  interp_lut u0 (.clk_i(clk), .rst_ni, .wr_en_i, .wr_addr_i, .wr_value_i,
                 .wr_diff_i, .valid_i, .data_i, .valid_o, .data_o);

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int idx_of(int x);
    logic [17:0] u = 18'(x);
    return int'({~u[17], u[16:8]});
  endfunction

  function automatic int expect_y(int x);
    logic [17:0] u = 18'(x);
    int f = int'(u[7:0]);
    int i = idx_of(x);
    int s = tv[i] + ((td[i] * f + 128) >>> 8);
    if (s > 131071) s = 131071;
    if (s < -131072) s = -131072;
    return s;
  endfunction

  task automatic wr(int a, int v, int d);
    @(negedge clk);
    wr_en_i = 1'b1; wr_addr_i = 10'(a); wr_value_i = 18'(v); wr_diff_i = 18'(d);
    tv[a] = v; td[a] = d;
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  // single sample; checks idle gap and strobe position (R2)
  task automatic run_one(string req, int x);
    @(negedge clk);
    valid_i = 1'b1; data_i = 18'(x);
    @(negedge clk);
    valid_i = 1'b0;
    @(negedge clk);
    chk("R2 early strobe", int'(valid_o), 0);
    @(negedge clk);
    chk("R2 strobe", int'(valid_o), 1);
    chk(req, int'($signed(data_o)), expect_y(x));
    @(negedge clk);
    chk("R2 single strobe", int'(valid_o), 0);
  endtask

  task automatic t_reset;
    chk("R1 valid", int'(valid_o), 0);
    chk("R1 data", int'(data_o), 0);
    @(negedge clk); rst_ni = 1'b1;
    @(negedge clk);
    chk("R1 after release", int'(valid_o), 0);
  endtask

  task automatic t_index_map;
    wr(0, 1000, 0); wr(512, -2000, 0); wr(1023, 3000, 256);
    run_one("R3 most negative", -131072);
    run_one("R3 zero", 0);
    run_one("R3 most positive", 131071);
  endtask

  task automatic t_frac;
    wr(600, 12345, 777);
    run_one("R5 frac zero", 88 * 256);
    run_one("R6 frac 100", 88 * 256 + 100);
    wr(601, 0, 1);
    run_one("R6 half up", 89 * 256 + 128);
    run_one("R6 below half", 89 * 256 + 127);
  endtask

  task automatic t_neg_diff;
    wr(100, 500, -3); wr(101, 500, -1);
    run_one("R7 diff -3 half", -131072 + 100 * 256 + 128);
    run_one("R7 diff -1 half", -131072 + 101 * 256 + 128);
  endtask

  task automatic t_sat;
    wr(1000, 131000, 131071);
    run_one("R8 positive clamp", 488 * 256 + 255);
    wr(5, -131000, -131072);
    run_one("R9 negative clamp", -131072 + 5 * 256 + 255);
  endtask

  task automatic t_rewrite;
    wr(600, -42, 0);
    run_one("R4 overwrite value", 88 * 256);
    run_one("R4 overwrite diff", 88 * 256 + 200);
  endtask

  task automatic t_burst;
    int xs [4] = '{88 * 256 + 7, 0, 131071, -131072 + 100 * 256 + 128};
    int last;
    for (int c = 0; c < 7; c++) begin
      @(negedge clk);
      if (c >= 3) begin
        chk("R2 burst strobe", int'(valid_o), 1);
        chk("R2 burst order", int'($signed(data_o)), expect_y(xs[c-3]));
      end
      valid_i = (c < 4);
      if (c < 4) data_i = 18'(xs[c]);
    end
    last = expect_y(xs[3]);
    for (int c = 0; c < 5; c++) begin
      @(negedge clk);
      chk("R10 hold", int'($signed(data_o)), last);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    t_index_map;
    t_frac;
    t_neg_diff;
    t_sat;
    t_rewrite;
    t_burst;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule